// File: doc/BRIEF.md
# Flash Read Sequencer with Burst Continuation

This block answers 32-bit word reads from a pipelined bus slave port by driving a quad-capable serial flash. It holds a small shift engine that moves 1 or 4 bits per flash clock, and a state machine that chains the command phases of a read: opcode, address, mode, dummy and data. A `quad_en` input picks the transfer style. When it is low, a single-line fast read is used. When it is high, a four-line read is used, and it sends a mode byte that asks the flash to stay in continuous-read mode.

Once the flash is in continuous-read mode, a later read in a new bus cycle skips the opcode and starts with the address. If `quad_en` has dropped while the flash is still in that mode, the block first runs a 32-clock release with all four lines high and only then issues a serial read. A bus request for the next word address is served by clocking further data out of the flash, which stays selected, without any new command. Any other request is stalled until the transfer has closed.

States: IDLE (deselected, accepts a request), EXIT (32-clock release), GAP (one deselected cycle after a release), OPC (opcode), ADDR (address), MODE (continuation byte), DUMMY (turnaround clocks), DATA (one word of read data), HOLD (flash still selected, clock stopped, waiting for the next bus request). Transitions: IDLE→OPC on a request in a fresh state, IDLE→ADDR on a quad request while continuous, IDLE→EXIT on a serial request while continuous, EXIT→GAP→OPC, OPC→ADDR, ADDR→MODE (quad) or ADDR→DUMMY (serial), MODE→DUMMY, DUMMY→DATA, DATA→HOLD, HOLD→DATA on a next-address request, HOLD→IDLE on a non-sequential request or when `bus_cyc` drops.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset `flash_cs_n` is 1, `flash_sck` is 0, `bus_ack` is 0 and `bus_stall` is 0, and the flash is treated as not continuous, so the first quad read sends an opcode.
- R2: With `quad_en` low, a read sends opcode 0x0B on line 0 MSB first, then the 24-bit byte address (word address shifted left by two) MSB first, then 8 dummy clocks, then 32 data clocks sampled on line 1. A lone first word takes 72 flash clocks and is acknowledged 148 system cycles after acceptance.
- R3: With `quad_en` high and the flash not continuous, a read sends 0xEB on line 0 for 8 clocks, the byte address as six nibbles (most significant first) on lines 3..0, the mode byte 0xA0 in two nibbles, 4 dummy clocks and 8 data clocks: 28 flash clocks, acknowledged 61 cycles after acceptance.
- R4: After any quad read, a quad read in a later bus cycle sends no opcode. It starts with the six address nibbles, then 0xA0, 4 dummy clocks and 8 data clocks: 20 flash clocks, acknowledged 44 cycles after acceptance.
- R5: A read with `quad_en` low while the flash is continuous first runs a 32-clock selected window with all four output lines at 1. It then deselects and performs the R2 read; the word is acknowledged 214 cycles after acceptance.
- R6: A request for the word address one above the last accepted one, made while `bus_cyc` stays high, keeps the flash selected. It adds 32 (serial) or 8 (quad) flash clocks and is acknowledged 65 or 17 cycles after acceptance.
- R7: Any other request during a transfer sees `bus_stall` high until the flash is deselected, and is then served by a complete new command.
- R8: Dropping `bus_cyc` while waiting between words deselects the flash on the next clock edge.
- R9: Bus words are little-endian: the first byte moved over the flash lines lands in bits 7:0, the fourth in bits 31:24.
- R10: `bus_ack` is high for exactly one cycle per accepted request, with `bus_rdata` valid in that cycle, and never without a request.
- R11: Each flash clock is one system cycle with `flash_sck` low followed by one with it high. `flash_sck` stays low whenever no bits are being shifted, and `flash_cs_n` is low whenever the shift engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_en | input | 1 | Selects four-line reads when high |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Read request strobe |
| bus_addr | input | AW | Word address of the request |
| bus_stall | output | 1 | Request cannot be taken this cycle |
| bus_ack | output | 1 | One-cycle read completion |
| bus_rdata | output | 32 | Read word, valid with `bus_ack` |
| flash_sck | output | 1 | Flash serial clock |
| flash_cs_n | output | 1 | Flash select, active low |
| flash_dout | output | 4 | Data toward the flash; line 0 in single-line phases |
| flash_din | input | 4 | Data from the flash; line 1 in single-line reads |

## Verification
Every phase costs twice its flash clock count plus one system cycle. This gives ack latencies of 148, 61, 44 and 214 cycles for the serial, fresh quad, continuous quad and release-then-serial first words, and 65 or 17 cycles for each next-address word. The bench records the cycle in which each request is taken and compares the measured latency at the sampling edge on which `bus_ack` is seen. It also compares the number of flash clocks counted by its flash model in each select window. Outputs are sampled on the falling system edge, and deselection is checked one cycle after `bus_cyc` drops.

// File: rtl/frs_pkg.sv
`timescale 1ns/1ps
package frs_pkg;

    localparam int WORD_W   = 32;
    localparam int BADDR_W  = 24;
    localparam int CW       = 6;

    localparam logic [7:0] OP_SER_READ  = 8'h0B;
    localparam logic [7:0] OP_QUAD_READ = 8'hEB;
    localparam logic [7:0] MODE_KEEP    = 8'hA0;

    localparam logic [CW-1:0] CK_OPC        = CW'(8);
    localparam logic [CW-1:0] CK_ADDR_SER   = CW'(BADDR_W);
    localparam logic [CW-1:0] CK_ADDR_QUAD  = CW'(BADDR_W / 4);
    localparam logic [CW-1:0] CK_MODE       = CW'(2);
    localparam logic [CW-1:0] CK_DUMMY_SER  = CW'(8);
    localparam logic [CW-1:0] CK_DUMMY_QUAD = CW'(4);
    localparam logic [CW-1:0] CK_DATA_SER   = CW'(WORD_W);
    localparam logic [CW-1:0] CK_DATA_QUAD  = CW'(WORD_W / 4);
    localparam logic [CW-1:0] CK_EXIT       = CW'(32);

    typedef enum logic [3:0] {
        S_IDLE,
        S_EXIT,
        S_GAP,
        S_OPC,
        S_ADDR,
        S_MODE,
        S_DUMMY,
        S_DATA,
        S_HOLD
    } frs_state_e;

    // first byte shifted in sits at the top; the bus wants it at the bottom
    function automatic logic [WORD_W-1:0] to_bus_order(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W / 8; i++) begin
            r[8*i +: 8] = w[WORD_W - 8*(i+1) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/frs_shifter.sv
`timescale 1ns/1ps
module frs_shifter
    import frs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     nclk,
    input  logic              quad,
    input  logic              rd,
    input  logic [WORD_W-1:0] wdata,
    input  logic [3:0]        din,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              sck,
    output logic [3:0]        dout
);

    logic              phase_hi;
    logic [CW-1:0]     left;
    logic [WORD_W-1:0] shreg;
    logic              q_r;
    logic              rd_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            phase_hi <= 1'b0;
            left     <= '0;
            shreg    <= '1;
            q_r      <= 1'b0;
            rd_r     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy     <= 1'b1;
                phase_hi <= 1'b0;
                left     <= nclk;
                shreg    <= wdata;
                q_r      <= quad;
                rd_r     <= rd;
            end else if (busy) begin
                if (!phase_hi) begin
                    phase_hi <= 1'b1;
                end else begin
                    phase_hi <= 1'b0;
                    if (q_r) begin
                        shreg <= {shreg[WORD_W-5:0], 4'hF};
                    end else begin
                        shreg <= {shreg[WORD_W-2:0], 1'b1};
                    end
                    if (rd_r) begin
                        if (q_r) begin
                            rdata <= {rdata[WORD_W-5:0], din};
                        end else begin
                            rdata <= {rdata[WORD_W-2:0], din[1]};
                        end
                    end
                    if (left == CW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        left <= left - CW'(1);
                    end
                end
            end
        end
    end

    assign sck  = phase_hi;
    assign dout = q_r ? shreg[WORD_W-1 -: 4] : {3'b111, shreg[WORD_W-1]};

    // the sequencer only launches a phase into an idle engine
    p_start_when_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    p_sck_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/frs_addr_track.sv
`timescale 1ns/1ps
module frs_addr_track #(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          bump,
    input  logic [AW-1:0] bus_addr,
    output logic [AW-1:0] cur,
    output logic          seq_hit
);

    logic [AW-1:0] next_addr;

    assign next_addr = cur + AW'(1);
    assign seq_hit   = (bus_addr == next_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= bus_addr;
        end else if (bump) begin
            cur <= next_addr;
        end
    end

endmodule

// File: rtl/frs_fsm.sv
`timescale 1ns/1ps
module frs_fsm
    import frs_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quad_en,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic [AW-1:0]     bus_addr,
    output logic              bus_stall,
    output logic              bus_ack,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [AW-1:0]     cur_addr,
    input  logic              seq_hit,
    output logic              take_new,
    output logic              take_seq,
    output logic              cs_n,
    output logic              eng_start,
    output logic [CW-1:0]     eng_nclk,
    output logic              eng_quad,
    output logic              eng_rd,
    output logic [WORD_W-1:0] eng_wdata,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_rdata
);

    frs_state_e         state, nxt;
    logic               cur_quad;
    logic               cont;
    logic [AW-1:0]      src_addr;
    logic [BADDR_W-1:0] byte_addr;
    logic               word_done;

    assign src_addr  = (state == S_IDLE) ? bus_addr : cur_addr;
    assign byte_addr = BADDR_W'({src_addr, 2'b00});
    assign word_done = (state == S_DATA) && eng_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_quad  <= 1'b0;
            cont      <= 1'b0;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= word_done;
            if (word_done) begin
                bus_rdata <= to_bus_order(eng_rdata);
            end
            if (take_new) begin
                cur_quad <= quad_en;
            end
            if (word_done && cur_quad) begin
                cont <= 1'b1;
            end else if (state == S_EXIT && eng_done) begin
                cont <= 1'b0;
            end
        end
    end

    always_comb begin
        nxt       = state;
        eng_start = 1'b0;
        eng_nclk  = '0;
        eng_quad  = cur_quad;
        eng_rd    = 1'b0;
        eng_wdata = '0;
        take_new  = 1'b0;
        take_seq  = 1'b0;
        bus_stall = 1'b1;
        cs_n      = 1'b0;
        unique case (state)
            S_IDLE: begin
                cs_n      = 1'b1;
                bus_stall = 1'b0;
                if (bus_cyc && bus_stb) begin
                    take_new  = 1'b1;
                    eng_start = 1'b1;
                    if (cont && quad_en) begin
                        nxt       = S_ADDR;
                        eng_nclk  = CK_ADDR_QUAD;
                        eng_quad  = 1'b1;
                        eng_wdata = {byte_addr, 8'h00};
                    end else if (cont) begin
                        nxt       = S_EXIT;
                        eng_nclk  = CK_EXIT;
                        eng_quad  = 1'b1;
                        eng_wdata = '1;
                    end else begin
                        nxt       = S_OPC;
                        eng_nclk  = CK_OPC;
                        eng_quad  = 1'b0;
                        eng_wdata = {(quad_en ? OP_QUAD_READ : OP_SER_READ), 24'h0};
                    end
                end
            end
            S_EXIT: begin
                if (eng_done) begin
                    nxt = S_GAP;
                end
            end
            S_GAP: begin
                cs_n      = 1'b1;
                nxt       = S_OPC;
                eng_start = 1'b1;
                eng_nclk  = CK_OPC;
                eng_quad  = 1'b0;
                eng_wdata = {OP_SER_READ, 24'h0};
            end
            S_OPC: begin
                if (eng_done) begin
                    nxt       = S_ADDR;
                    eng_start = 1'b1;
                    eng_nclk  = cur_quad ? CK_ADDR_QUAD : CK_ADDR_SER;
                    eng_wdata = {byte_addr, 8'h00};
                end
            end
            S_ADDR: begin
                if (eng_done) begin
                    eng_start = 1'b1;
                    if (cur_quad) begin
                        nxt       = S_MODE;
                        eng_nclk  = CK_MODE;
                        eng_wdata = {MODE_KEEP, 24'h0};
                    end else begin
                        nxt      = S_DUMMY;
                        eng_nclk = CK_DUMMY_SER;
                        eng_rd   = 1'b1;
                    end
                end
            end
            S_MODE: begin
                if (eng_done) begin
                    nxt       = S_DUMMY;
                    eng_start = 1'b1;
                    eng_nclk  = CK_DUMMY_QUAD;
                    eng_rd    = 1'b1;
                end
            end
            S_DUMMY: begin
                if (eng_done) begin
                    nxt       = S_DATA;
                    eng_start = 1'b1;
                    eng_nclk  = cur_quad ? CK_DATA_QUAD : CK_DATA_SER;
                    eng_rd    = 1'b1;
                end
            end
            S_DATA: begin
                if (eng_done) begin
                    nxt = S_HOLD;
                end
            end
            S_HOLD: begin
                bus_stall = !seq_hit;
                if (!bus_cyc) begin
                    nxt = S_IDLE;
                end else if (bus_stb) begin
                    if (seq_hit) begin
                        take_seq  = 1'b1;
                        nxt       = S_DATA;
                        eng_start = 1'b1;
                        eng_nclk  = cur_quad ? CK_DATA_QUAD : CK_DATA_SER;
                        eng_rd    = 1'b1;
                    end else begin
                        nxt = S_IDLE;
                    end
                end
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    p_ack_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    p_cont_from_quad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cont) |-> cur_quad);
    p_accept_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && bus_cyc && bus_stb) |=> state != S_IDLE);
    p_hold_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && bus_cyc) |-> !cs_n);

endmodule

// File: rtl/flash_rd_seq.sv
`timescale 1ns/1ps
module flash_rd_seq
    import frs_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quad_en,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic [AW-1:0]     bus_addr,
    output logic              bus_stall,
    output logic              bus_ack,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              flash_sck,
    output logic              flash_cs_n,
    output logic [3:0]        flash_dout,
    input  logic [3:0]        flash_din
);

    logic [AW-1:0]     cur_addr;
    logic              seq_hit;
    logic              take_new;
    logic              take_seq;
    logic              eng_start;
    logic [CW-1:0]     eng_nclk;
    logic              eng_quad;
    logic              eng_rd;
    logic [WORD_W-1:0] eng_wdata;
    logic              eng_busy;
    logic              eng_done;
    logic [WORD_W-1:0] eng_rdata;

    frs_addr_track #(.AW(AW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_new),
        .bump     (take_seq),
        .bus_addr (bus_addr),
        .cur      (cur_addr),
        .seq_hit  (seq_hit)
    );

    frs_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .quad_en   (quad_en),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb),
        .bus_addr  (bus_addr),
        .bus_stall (bus_stall),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .cur_addr  (cur_addr),
        .seq_hit   (seq_hit),
        .take_new  (take_new),
        .take_seq  (take_seq),
        .cs_n      (flash_cs_n),
        .eng_start (eng_start),
        .eng_nclk  (eng_nclk),
        .eng_quad  (eng_quad),
        .eng_rd    (eng_rd),
        .eng_wdata (eng_wdata),
        .eng_done  (eng_done),
        .eng_rdata (eng_rdata)
    );

    frs_shifter u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .nclk  (eng_nclk),
        .quad  (eng_quad),
        .rd    (eng_rd),
        .wdata (eng_wdata),
        .din   (flash_din),
        .busy  (eng_busy),
        .done  (eng_done),
        .rdata (eng_rdata),
        .sck   (flash_sck),
        .dout  (flash_dout)
    );

    p_select_while_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !flash_cs_n);
    p_no_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_cs_n && !$past(flash_cs_n)) |-> !bus_ack);

endmodule

// File: tb/flash_rd_seq_bench.sv
`timescale 1ns/1ps
module flash_rd_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          quad_en = 1'b0;
    logic          bus_cyc = 1'b0;
    logic          bus_stb = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_stall;
    logic          bus_ack;
    logic [31:0]   bus_rdata;
    logic          flash_sck;
    logic          flash_cs_n;
    logic [3:0]    flash_dout;
    logic [3:0]    flash_din = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_rd_seq #(.AW(AW)) u_flash_rd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .quad_en    (quad_en),
        .bus_cyc    (bus_cyc),
        .bus_stb    (bus_stb),
        .bus_addr   (bus_addr),
        .bus_stall  (bus_stall),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .flash_sck  (flash_sck),
        .flash_cs_n (flash_cs_n),
        .flash_dout (flash_dout),
        .flash_din  (flash_din)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ (a[23:16] + 8'h6B);
    endfunction

    function automatic logic [31:0] fword(input logic [AW-1:0] w);
        logic [23:0] b;
        b = 24'({w, 2'b00});
        return {fbyte(b + 24'd3), fbyte(b + 24'd2), fbyte(b + 24'd1), fbyte(b)};
    endfunction

    function automatic int first_lat(input bit quad, input bit cont);
        if (quad) return cont ? 44 : 61;
        return cont ? 214 : 148;
    endfunction

    function automatic int first_clks(input bit quad, input bit cont);
        if (quad) return cont ? 20 : 28;
        return 72;
    endfunction

    // ---------------- flash model ----------------
    int          m_clk;
    int          m_kind;
    bit          m_cont = 1'b0;
    bit          m_in = 1'b0;
    bit          m_ones;
    logic [7:0]  m_opc;
    logic [7:0]  m_mode;
    logic [23:0] m_addr;
    int          win_n = 0;
    int          w_clk [64];
    int          w_kind [64];
    logic [7:0]  w_opc [64];
    logic [7:0]  w_mode [64];
    logic [23:0] w_addr [64];
    bit          w_ones [64];

    always @(negedge flash_cs_n) begin
        m_in   = 1'b1;
        m_clk  = 0;
        m_opc  = 8'h0;
        m_mode = 8'h0;
        m_addr = 24'h0;
        m_ones = 1'b1;
        m_kind = m_cont ? 3 : 0;
    end

    always @(posedge flash_sck) begin
        if (!flash_cs_n) begin
            m_clk++;
            if (flash_dout != 4'hF) m_ones = 1'b0;
            case (m_kind)
                0: begin
                    m_opc = {m_opc[6:0], flash_dout[0]};
                    if (m_clk == 8) m_kind = (m_opc == 8'h0B) ? 1 : (m_opc == 8'hEB) ? 2 : 4;
                end
                1: if (m_clk <= 32) m_addr = {m_addr[22:0], flash_dout[0]};
                2: begin
                    if (m_clk <= 14) m_addr = {m_addr[19:0], flash_dout};
                    else if (m_clk <= 16) m_mode = {m_mode[3:0], flash_dout};
                end
                3: begin
                    if (m_clk <= 6) m_addr = {m_addr[19:0], flash_dout};
                    else if (m_clk <= 8) m_mode = {m_mode[3:0], flash_dout};
                end
                default: ;
            endcase
        end
    end

    always @(negedge flash_sck) begin
        if (!flash_cs_n) begin
            int ds;
            int u;
            logic [7:0] b;
            ds = (m_kind == 1) ? 40 : (m_kind == 2) ? 20 : (m_kind == 3) ? 12 : -1;
            if (ds >= 0 && m_clk >= ds) begin
                u = m_clk - ds;
                if (m_kind == 1) begin
                    b = fbyte(m_addr + 24'(u / 8));
                    flash_din <= {2'b00, b[7 - (u % 8)], 1'b0};
                end else begin
                    b = fbyte(m_addr + 24'(u / 2));
                    flash_din <= (u % 2 == 0) ? b[7:4] : b[3:0];
                end
            end
        end
    end

    always @(posedge flash_cs_n) begin
        if (m_in) begin
            m_in = 1'b0;
            if (win_n < 64) begin
                w_clk[win_n]  = m_clk;
                w_kind[win_n] = m_kind;
                w_opc[win_n]  = m_opc;
                w_mode[win_n] = m_mode;
                w_addr[win_n] = m_addr;
                w_ones[win_n] = m_ones;
            end
            win_n++;
            if (m_kind == 2 || m_kind == 3) m_cont = (m_mode == 8'hA0);
        end
    end

    // ---------------- ack monitor and cycle count ----------------
    int          ncnt = 0;
    int          n_req = 0;
    int          n_ack = 0;
    int          acc_t [256];
    int          exp_l [256];
    logic [31:0] exp_w [256];
    int          sck_err = 0;
    logic        prev_sck = 1'b0;

    always @(negedge clk) begin
        if (rst_n && flash_sck && prev_sck) sck_err++;
        prev_sck <= flash_sck;
        if (rst_n && bus_ack) begin
            if (n_ack >= n_req) begin
                chk(1'b0, "R10", "ack without request", 1, 0);
            end else begin
                chk(bus_rdata == exp_w[n_ack], "R9", "read word", bus_rdata, exp_w[n_ack]);
                if (exp_l[n_ack] != 0)
                    chk((ncnt - acc_t[n_ack]) == exp_l[n_ack], "R2-R6 latency", "ack cycle",
                        ncnt - acc_t[n_ack], exp_l[n_ack]);
            end
            n_ack++;
        end
        ncnt <= ncnt + 1;
    end

    // ---------------- drivers ----------------
    int last_stalls;
    bit exp_cont = 1'b0;

    task automatic issue(input logic [AW-1:0] a, input int lat);
        @(negedge clk);
        bus_stb  = 1'b1;
        bus_addr = a;
        last_stalls = 0;
        #1;
        while (bus_stall) begin
            last_stalls++;
            @(negedge clk);
            #1;
        end
        acc_t[n_req] = ncnt;
        exp_w[n_req] = fword(a);
        exp_l[n_req] = lat;
        n_req++;
        @(negedge clk);
        bus_stb = 1'b0;
    endtask

    task automatic finish_cycle();
        while (n_ack < n_req) @(negedge clk);
        @(negedge clk);
        bus_cyc = 1'b0;
        @(negedge clk);
        chk(flash_cs_n == 1'b1, "R8", "deselect after cyc drop", flash_cs_n, 1);
        chk(flash_sck == 1'b0, "R11", "sck parked", flash_sck, 0);
    endtask

    task automatic check_win(input int idx, input bit quad, input bit cont,
                             input logic [AW-1:0] a, input int n);
        int clks;
        clks = first_clks(quad, cont) + (n - 1) * (quad ? 8 : 32);
        chk(w_clk[idx] == clks, n > 1 ? "R6" : (quad ? (cont ? "R4" : "R3") : "R2"),
            "window flash clocks", w_clk[idx], clks);
        chk(w_addr[idx] == 24'({a, 2'b00}), "R2", "byte address", w_addr[idx], 24'({a, 2'b00}));
        if (!quad) begin
            chk(w_opc[idx] == 8'h0B, "R2", "serial opcode", w_opc[idx], 8'h0B);
        end else if (!cont) begin
            chk(w_opc[idx] == 8'hEB && w_kind[idx] == 2, "R3", "quad opcode", w_opc[idx], 8'hEB);
            chk(w_mode[idx] == 8'hA0, "R3", "mode byte", w_mode[idx], 8'hA0);
        end else begin
            chk(w_kind[idx] == 3, "R4", "no opcode in continuous read", w_kind[idx], 3);
            chk(w_mode[idx] == 8'hA0, "R4", "mode byte", w_mode[idx], 8'hA0);
        end
    endtask

    task automatic burst(input logic [AW-1:0] a, input int n, input bit quad);
        int w0;
        bit ex;
        w0 = win_n;
        ex = !quad && exp_cont;
        @(negedge clk);
        quad_en = quad;
        bus_cyc = 1'b1;
        for (int i = 0; i < n; i++) begin
            issue(a + AW'(i), i == 0 ? first_lat(quad, exp_cont) : (quad ? 17 : 65));
        end
        finish_cycle();
        if (ex) begin
            chk(w_clk[w0] == 32 && w_ones[w0], "R5", "release window", w_clk[w0], 32);
            w0++;
        end
        check_win(w0, quad, quad && exp_cont, a, n);
        chk(win_n == w0 + 1, "R6", "select windows per burst", win_n, w0 + 1);
        exp_cont = quad ? 1'b1 : 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(negedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int w0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(flash_cs_n == 1'b1, "R1", "cs_n in reset", flash_cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flash_cs_n == 1'b1, "R1", "cs_n after reset", flash_cs_n, 1);
        chk(flash_sck == 1'b0, "R1", "sck after reset", flash_sck, 0);
        chk(bus_ack == 1'b0, "R1", "ack after reset", bus_ack, 0);
        chk(bus_stall == 1'b0, "R1", "stall after reset", bus_stall, 0);

        burst(22'h000123, 1, 1'b0);          // R2 lone serial word
        burst(22'h00ABC0, 3, 1'b0);          // R6 serial streaming
        burst(22'h001000, 1, 1'b1);          // R3 first quad read uses opcode
        burst(22'h002040, 1, 1'b1);          // R4 continuous read
        burst(22'h3FFF00, 3, 1'b1);          // R6 quad streaming

        // R7 non-sequential request inside one cycle
        w0 = win_n;
        @(negedge clk);
        quad_en = 1'b1;
        bus_cyc = 1'b1;
        issue(22'h000400, 44);
        issue(22'h000401, 17);
        issue(22'h00040B, 0);
        chk(last_stalls > 0, "R7", "non-sequential stalled", last_stalls, 1);
        exp_l[n_req - 1] = 44;
        finish_cycle();
        chk(win_n == w0 + 2, "R7", "new select window", win_n, w0 + 2);
        check_win(w0, 1'b1, 1'b1, 22'h000400, 2);
        check_win(w0 + 1, 1'b1, 1'b1, 22'h00040B, 1);

        burst(22'h0200AA, 2, 1'b0);          // R5 release then serial

        for (int k = 0; k < 8; k++) begin
            burst(AW'($urandom_range(0, (1 << AW) - 8)), $urandom_range(1, 4), 1'($urandom_range(0, 1)));
        end

        repeat (20) @(negedge clk);
        chk(n_ack == n_req, "R10", "acks equal requests", n_ack, n_req);
        chk(sck_err == 0, "R11", "sck high for one cycle", sck_err, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule